// File: doc/BRIEF.md
# Per-Input Circular Page Recorder

This block holds the recording state for one signal input whose samples are stored as fixed-size pages in a region of a large shared page-addressed memory. Software gives the input a region by setting a first page and a page count. It then starts recording or freezes it with a level control. A packer upstream sends a one-cycle pulse each time it finishes a page, together with that page's sequence number. On each accepted pulse the block commits the page to the current write address and moves to the next page slot. The slot wraps back to the first page of the region after the allocated number of pages.

The block also reports, for monitoring, the last page written and its sequence number. It reports the number of pages in the region that hold fresh data, and whether that number has reached the region size. Once the region is full, every further page overwrites the oldest one. The page addresses it produces are absolute: the region offset is added to the first page, modulo the memory size, so a region may straddle the top of memory. Memory access and write arbitration are left to neighbouring blocks.

Top module: `page_ring_recorder`

## Requirements
- R1: Out of reset the block is not recording, and the write page, last page, last sequence number and fresh-page count all read zero.
- R2: While not recording, page-done pulses change neither the last page, the last sequence number, the fresh-page count nor the write page.
- R3: In the stop state, a high record enable with a nonzero page count moves the block to record, and the recording flag rises on the clock edge after the enable was sampled. A low record enable in record returns the block to stop, and the flag falls on the following edge.
- R4: An allocation with a page count of zero never enters record, whatever the record enable does.
- R5: On each page-done pulse accepted in record, the last page takes the write page shown in that cycle and the last sequence number takes the page sequence input. The write page then moves to the next slot.
- R6: After the allocated number of accepted pages, the write page returns to the first page of the region.
- R7: The write page equals the first page plus the slot offset, modulo the memory size (default 2^21 pages, page index 21 bits), so a region may run past the top page and continue at page 0.
- R8: The fresh-page count rises by one per accepted page and stays at the region size once it gets there. The full flag is high exactly when the count equals a nonzero region size.
- R9: Freezing and then resuming keeps the fresh-page count, the last page and the write slot; the region is not cleared.
- R10: Allocation inputs changed while in record have no effect on the write page or the region until the block is next in stop; then they take effect.
- R11: When a new allocation is applied in stop, the fresh-page count returns to zero and the write page moves to the new first page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_start_i | input | PAGE_W | First page of the region |
| alloc_count_i | input | PAGE_W+1 | Number of pages in the region; zero means no buffer |
| rec_en_i | input | 1 | Level control: high records, low freezes |
| page_done_i | input | 1 | One-cycle pulse: the current page has been filled |
| page_seq_i | input | SEQ_W | Sequence number of the page being completed |
| wr_page_o | output | PAGE_W | Absolute page to write the current page to |
| recording_o | output | 1 | High while in the record state |
| last_page_o | output | PAGE_W | Absolute index of the last committed page |
| last_seq_o | output | SEQ_W | Sequence number of the last committed page |
| fresh_pages_o | output | PAGE_W+1 | Count of fresh pages in the region, saturating at its size |
| full_o | output | 1 | Region holds only fresh pages |

## Verification
The main function is tried with a small region of three pages driven through five pages. This separates a correct wrap back to the first page from a pointer that overruns, and a count that saturates from one that keeps rising. A four-page region placed two pages below the top of memory tells a correct modulo address apart from a plain sum or a wrap inside the region only. Page pulses sent while frozen, while a zero-size allocation is applied, and around allocation changes made during record each check a different guard. The guards are: a stop-state hold, the no-buffer case, and the deferral of new allocations. A freeze-resume pair shows whether the state survives or is wrongly cleared.

// File: rtl/prr_pkg.sv
package prr_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_STOP   = 2'd1,
        ST_RECORD = 2'd2
    } rec_state_e;
endpackage

// File: rtl/prr_ctrl.sv
// Recording state machine and the active allocation registers.
module prr_ctrl
    import prr_pkg::*;
#(
    parameter int PAGE_W = 21,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] alloc_start_i,
    input  logic [CNT_W-1:0]  alloc_count_i,
    input  logic              rec_en_i,
    output logic [PAGE_W-1:0] start_o,
    output logic [CNT_W-1:0]  size_o,
    output logic              reload_o,
    output logic              recording_o
);
    typedef struct packed {
        rec_state_e        state;
        logic [PAGE_W-1:0] start;
        logic [CNT_W-1:0]  size;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  reload_d;

    always_comb begin
        ctrl_d   = ctrl_q;
        reload_d = 1'b0;
        case (ctrl_q.state)
            ST_RESET: ctrl_d.state = ST_STOP;
            ST_STOP: begin
                // Pick up a new allocation only while stopped.
                if (alloc_start_i != ctrl_q.start || alloc_count_i != ctrl_q.size) begin
                    reload_d     = 1'b1;
                    ctrl_d.start = alloc_start_i;
                    ctrl_d.size  = alloc_count_i;
                end
                if (rec_en_i && alloc_count_i != '0) begin
                    ctrl_d.state = ST_RECORD;
                end
            end
            ST_RECORD: begin
                if (!rec_en_i) begin
                    ctrl_d.state = ST_STOP;
                end
            end
            default: ctrl_d.state = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_RESET, start: '0, size: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start_o     = ctrl_q.start;
    assign size_o      = ctrl_q.size;
    assign reload_o    = reload_d;
    assign recording_o = (ctrl_q.state == ST_RECORD);
endmodule

// File: rtl/prr_ring_ptr.sv
// Slot offset inside the region, wrapping after size slots.
module prr_ring_ptr #(
    parameter int PAGE_W = 21,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [CNT_W-1:0]  size_i,
    output logic [PAGE_W-1:0] offset_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] offset;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        ptr_d = ptr_q;
        inc   = {1'b0, ptr_q.offset} + CNT_W'(1);
        if (clear_i) begin
            ptr_d.offset = '0;
        end else if (step_i) begin
            ptr_d.offset = (inc >= size_i) ? '0 : inc[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign offset_o = ptr_q.offset;
endmodule

// File: rtl/prr_fresh_cnt.sv
// Saturating count of fresh pages held in the region.
module prr_fresh_cnt #(
    parameter int PAGE_W = 21,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] size_i,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.count = '0;
        end else if (step_i && cnt_q.count < size_i) begin
            cnt_d.count = cnt_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;
    assign full_o  = (size_i != '0) && (cnt_q.count == size_i);
endmodule

// File: rtl/prr_page_map.sv
// Absolute page = first page + offset, modulo the memory size.
module prr_page_map #(
    parameter int PAGE_W    = 21,
    parameter int MEM_PAGES = 2 ** PAGE_W,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] offset_i,
    output logic [PAGE_W-1:0] page_o
);
    localparam logic [CNT_W-1:0] MEM_L = CNT_W'(MEM_PAGES);

    logic [CNT_W-1:0] sum;
    logic [CNT_W-1:0] wrapped;

    always_comb begin
        sum     = {1'b0, start_i} + {1'b0, offset_i};
        wrapped = (sum >= MEM_L) ? (sum - MEM_L) : sum;
        page_o  = wrapped[PAGE_W-1:0];
    end
endmodule

// File: rtl/page_ring_recorder.sv
module page_ring_recorder
    import prr_pkg::*;
#(
    parameter int PAGE_W    = 21,
    parameter int SEQ_W     = 64,
    parameter int MEM_PAGES = 2 ** PAGE_W,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] alloc_start_i,
    input  logic [CNT_W-1:0]  alloc_count_i,
    input  logic              rec_en_i,
    input  logic              page_done_i,
    input  logic [SEQ_W-1:0]  page_seq_i,
    output logic [PAGE_W-1:0] wr_page_o,
    output logic              recording_o,
    output logic [PAGE_W-1:0] last_page_o,
    output logic [SEQ_W-1:0]  last_seq_o,
    output logic [CNT_W-1:0]  fresh_pages_o,
    output logic              full_o
);
    logic [PAGE_W-1:0] start_w;
    logic [CNT_W-1:0]  size_w;
    logic              reload_w;
    logic              rec_w;
    logic [PAGE_W-1:0] offset_w;
    logic [PAGE_W-1:0] page_w;
    logic              accept_w;

    prr_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_start_i(alloc_start_i),
        .alloc_count_i(alloc_count_i),
        .rec_en_i     (rec_en_i),
        .start_o      (start_w),
        .size_o       (size_w),
        .reload_o     (reload_w),
        .recording_o  (rec_w)
    );

    assign accept_w = rec_w && page_done_i;

    prr_ring_ptr #(.PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (reload_w),
        .step_i  (accept_w),
        .size_i  (size_w),
        .offset_o(offset_w)
    );

    prr_fresh_cnt #(.PAGE_W(PAGE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(reload_w),
        .step_i (accept_w),
        .size_i (size_w),
        .count_o(fresh_pages_o),
        .full_o (full_o)
    );

    prr_page_map #(.PAGE_W(PAGE_W), .MEM_PAGES(MEM_PAGES)) u_map (
        .start_i (start_w),
        .offset_i(offset_w),
        .page_o  (page_w)
    );

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SEQ_W-1:0]  seq;
    } last_t;

    last_t last_d, last_q;

    always_comb begin
        last_d = last_q;
        if (accept_w) begin
            last_d.page = page_w;
            last_d.seq  = page_seq_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= last_d;
        end
    end

    assign wr_page_o   = page_w;
    assign recording_o = rec_w;
    assign last_page_o = last_q.page;
    assign last_seq_o  = last_q.seq;
endmodule

// File: rtl/page_ring_recorder_chk.sv
module page_ring_recorder_chk #(
    parameter int PAGE_W = 21,
    parameter int SEQ_W  = 64,
    localparam int CNT_W = PAGE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_en_i,
    input logic              recording_o,
    input logic [PAGE_W-1:0] last_page_o,
    input logic [SEQ_W-1:0]  last_seq_o,
    input logic [CNT_W-1:0]  fresh_pages_o,
    input logic [PAGE_W-1:0] start_w,
    input logic [CNT_W-1:0]  size_w
);
    // R3
    rec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recording_o) |-> !$past(rec_en_i));

    // R4
    zero_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recording_o |-> (size_w != '0));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !recording_o |=> ($stable(last_seq_o) && $stable(last_page_o)));

    // R8
    fresh_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_pages_o <= size_w);

    // R10
    alloc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recording_o |=> ($stable(start_w) && $stable(size_w)));
endmodule

bind page_ring_recorder page_ring_recorder_chk #(.PAGE_W(PAGE_W), .SEQ_W(SEQ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_en_i     (rec_en_i),
    .recording_o  (recording_o),
    .last_page_o  (last_page_o),
    .last_seq_o   (last_seq_o),
    .fresh_pages_o(fresh_pages_o),
    .start_w      (start_w),
    .size_w       (size_w)
);

// File: tb/sim_page_ring_recorder.sv
`timescale 1ns/1ps
module sim_page_ring_recorder;
    localparam int PAGE_W = 21;
    localparam int SEQ_W  = 64;
    localparam int CNT_W  = PAGE_W + 1;
    localparam int MEMP   = 2 ** PAGE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PAGE_W-1:0] alloc_start = '0;
    logic [CNT_W-1:0]  alloc_count = '0;
    logic              rec_en = 1'b0;
    logic              page_done = 1'b0;
    logic [SEQ_W-1:0]  page_seq = '0;
    logic [PAGE_W-1:0] wr_page;
    logic              recording;
    logic [PAGE_W-1:0] last_page;
    logic [SEQ_W-1:0]  last_seq;
    logic [CNT_W-1:0]  fresh_pages;
    logic              full;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    page_ring_recorder #(.PAGE_W(PAGE_W), .SEQ_W(SEQ_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_start_i(alloc_start),
        .alloc_count_i(alloc_count),
        .rec_en_i     (rec_en),
        .page_done_i  (page_done),
        .page_seq_i   (page_seq),
        .wr_page_o    (wr_page),
        .recording_o  (recording),
        .last_page_o  (last_page),
        .last_seq_o   (last_seq),
        .fresh_pages_o(fresh_pages),
        .full_o       (full)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_page(input logic [SEQ_W-1:0] seq);
        @(negedge clk);
        page_done = 1'b1;
        page_seq  = seq;
        @(negedge clk);
        page_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "recording", 64'(recording), 0);
        chk("R1", "wr_page", 64'(wr_page), 0);
        chk("R1", "last_page", 64'(last_page), 0);
        chk("R1", "last_seq", last_seq, 0);
        chk("R1", "fresh", 64'(fresh_pages), 0);
    endtask

    task automatic t_stop_ignore();
        alloc_start = 21'd100;
        alloc_count = 22'd3;
        @(negedge clk);
        chk("R11", "wr_page after alloc", 64'(wr_page), 100);
        pulse_page(64'd7);
        chk("R2", "last_seq in stop", last_seq, 0);
        chk("R2", "fresh in stop", 64'(fresh_pages), 0);
        chk("R2", "wr_page in stop", 64'(wr_page), 100);
    endtask

    task automatic t_record();
        rec_en = 1'b1;
        @(negedge clk);
        chk("R3", "recording rises", 64'(recording), 1);
        for (int k = 0; k < 5; k++) begin
            int exp_pg;
            int exp_cnt;
            exp_pg  = 100 + (k % 3);
            exp_cnt = (k + 1 > 3) ? 3 : k + 1;
            chk("R6", "wr_page before pulse", 64'(wr_page), 64'(exp_pg));
            pulse_page(64'(1000 + k));
            chk("R5", "last_page", 64'(last_page), 64'(exp_pg));
            chk("R5", "last_seq", last_seq, 64'(1000 + k));
            chk("R8", "fresh", 64'(fresh_pages), 64'(exp_cnt));
            chk("R8", "full", 64'(full), (k >= 2) ? 1 : 0);
        end
    endtask

    task automatic t_freeze_resume();
        rec_en = 1'b0;
        @(negedge clk);
        chk("R3", "recording falls", 64'(recording), 0);
        pulse_page(64'd55);
        chk("R2", "last_seq frozen", last_seq, 1004);
        chk("R9", "fresh frozen", 64'(fresh_pages), 3);
        chk("R9", "wr_page frozen", 64'(wr_page), 102);
        rec_en = 1'b1;
        @(negedge clk);
        chk("R9", "recording resumed", 64'(recording), 1);
        chk("R9", "wr_page kept", 64'(wr_page), 102);
        chk("R9", "fresh kept", 64'(fresh_pages), 3);
        chk("R9", "last_page kept", 64'(last_page), 101);
    endtask

    task automatic t_realloc_busy();
        alloc_start = 21'd500;
        alloc_count = 22'd2;
        @(negedge clk);
        chk("R10", "wr_page ignores alloc", 64'(wr_page), 102);
        pulse_page(64'd2000);
        chk("R10", "last_page old region", 64'(last_page), 102);
        chk("R10", "wr_page wraps old region", 64'(wr_page), 100);
        chk("R10", "fresh old size", 64'(fresh_pages), 3);
        rec_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "wr_page new start", 64'(wr_page), 500);
        chk("R11", "fresh cleared", 64'(fresh_pages), 0);
        chk("R11", "full cleared", 64'(full), 0);
    endtask

    task automatic t_zero_alloc();
        alloc_start = 21'd9;
        alloc_count = 22'd0;
        rec_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4", "no record with zero pages", 64'(recording), 0);
        pulse_page(64'd3000);
        chk("R4", "last_seq untouched", last_seq, 2000);
        chk("R4", "fresh untouched", 64'(fresh_pages), 0);
        rec_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wrap_top();
        alloc_start = 21'(MEMP - 2);
        alloc_count = 22'd4;
        @(negedge clk);
        rec_en = 1'b1;
        @(negedge clk);
        chk("R3", "recording wrap region", 64'(recording), 1);
        for (int k = 0; k < 5; k++) begin
            int exp_pg;
            exp_pg = (MEMP - 2 + (k % 4)) % MEMP;
            chk("R7", "wr_page across top", 64'(wr_page), 64'(exp_pg));
            pulse_page(64'(4000 + k));
            chk("R7", "last_page across top", 64'(last_page), 64'(exp_pg));
        end
        chk("R8", "fresh saturated", 64'(fresh_pages), 4);
        rec_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_stop_ignore();
        t_record();
        t_freeze_resume();
        t_realloc_busy();
        t_zero_alloc();
        t_wrap_top();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule